// File: doc/BRIEF.md
# Framed-Payload Pseudo-Random Pattern Generator and Checker

This block places a maximal-length pseudo-random test sequence (period 32 767 bits) into the payload of a 2.048 Mbit/s framed stream, and checks the same kind of sequence on the receive side. A framer supplies a one-cycle bit strobe (`bit_en`) and the number of the current timeslot (`ts_num`). Timeslot 0 carries frame overhead, so it holds no pattern bits. The other 31 timeslots do carry pattern bits, which gives a net pattern rate of 1 984 kbit/s. The sequence does not restart at a frame boundary. It pauses for the overhead bits and then continues from where it stopped.

On the transmit side the block presents the next sequence bit on `tx_bit` during each payload bit slot. On the receive side the checker synchronises to the incoming payload bits by itself, reports when it holds lock, and counts bit errors in a saturating counter. Test equipment uses the block to prove error-free transfer of the payload: a passing run shows lock and an error count of zero.

Top module: `e1_prbs_engine`

## Requirements
- R1: After reset the transmit register holds all ones. Each payload bit sent equals the XOR of the bits sent 14 and 15 payload bits earlier, and the register holds those bits (generator x^15 + x^14 + 1, so the first payload bit after reset is 0). The register never reaches the all-zero state.
- R2: A payload slot is a cycle with `bit_en` = 1 and `ts_num` not equal to 0. Timeslot 16 counts as a payload slot. The sequence advances only in payload slots. `tx_bit` is 0 whenever `ts_num` is 0.
- R3: `rx_bit` has no effect on `locked` or `err_count` in a cycle where `bit_en` is 0 or `ts_num` is 0.
- R4: Acquisition works as follows. After reset or after loss of lock, the first 15 received payload bits are loaded into the checker register. The checker then asserts `locked` after 64 consecutive received payload bits that each match its prediction.
- R5: While locked, the reference register runs freely and does not reload from the line. A single flipped received bit therefore adds exactly one error.
- R6: While locked, payload bits are grouped into blocks of 64. The first block starts at the first bit after lock is gained. When the 8th mismatch within one block occurs, `locked` drops and acquisition (R4) restarts.
- R7: `err_count` counts mismatches only while locked, by at most one per bit, and holds at its all-ones value instead of wrapping.
- R8: `err_clr` = 1 sets `err_count` to 0 at the next clock edge. The clear takes priority over an increment in the same cycle, and it leaves `locked` unchanged.
- R9: An all-zero checker register never counts as a match, so a stuck-at-zero input never gives lock.
- R10: While reset is held, and after it is released, `locked` is 0 and `err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per line bit |
| ts_num | input | TS_W (5) | Timeslot number of the current bit, 0..31 |
| err_clr | input | 1 | Synchronous clear of the error counter |
| rx_bit | input | 1 | Received line bit |
| tx_bit | output | 1 | Pattern bit for the current payload slot, 0 in timeslot 0 |
| locked | output | 1 | Receive checker holds sequence lock |
| err_count | output | CNT_W (32) | Saturating count of bit errors found while locked |

## Verification
A wrong advance rule in the generator, such as stepping during timeslot 0 or failing to step during timeslot 16, puts `tx_bit` out of step with the recurrence. This shows up at the first payload bit after the affected timeslot. A checker that reloads from the line while locked turns one injected error into three counted errors, and this is visible one clock after the flipped bit. A wrong block or threshold for loss of lock changes the payload bit at which `locked` falls. The stimulus places errors so that block boundaries fall at known bit positions. Errors counted before lock, a counter that wraps, and a clear that loses to an increment each change `err_count` within one clock.

// File: rtl/e1_prbs_pkg.sv
package e1_prbs_pkg;

    localparam int PRBS_W = 15;

    // Feedback taps for x^15 + x^14 + 1 on a register whose bit 0 is the newest bit
    function automatic logic prbs_next(input logic [PRBS_W-1:0] s);
        return s[PRBS_W-1] ^ s[PRBS_W-2];
    endfunction

endpackage

// File: rtl/e1_prbs_gen.sv
module e1_prbs_gen
    import e1_prbs_pkg::*;
#(
    parameter logic [PRBS_W-1:0] SEED = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic seq_bit
);

    typedef struct packed {
        logic [PRBS_W-1:0] lfsr;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.lfsr = {st_q.lfsr[PRBS_W-2:0], prbs_next(st_q.lfsr)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{lfsr: SEED};
        else        st_q <= st_d;
    end

    assign seq_bit = prbs_next(st_q.lfsr);

endmodule

// File: rtl/e1_prbs_chk.sv
module e1_prbs_chk
    import e1_prbs_pkg::*;
#(
    parameter int LOCK_RUN  = 64,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic rx_bit,
    output logic locked,
    output logic err_hit
);

    localparam int FILL_W = $clog2(PRBS_W + 1);
    localparam int RUN_W  = $clog2(LOCK_RUN);
    localparam int WIN_W  = $clog2(WIN_LEN);
    localparam int ERR_W  = $clog2(LOSS_ERRS + 1);

    typedef struct packed {
        logic [PRBS_W-1:0] sr;
        logic [FILL_W-1:0] fill;
        logic              locked;
        logic [RUN_W-1:0]  run;
        logic [WIN_W-1:0]  win;
        logic [ERR_W-1:0]  werr;
    } chk_st_t;

    chk_st_t st_d, st_q;
    logic    pred;
    logic    miss;
    logic    hit_d;

    always_comb begin
        st_d  = st_q;
        hit_d = 1'b0;
        pred  = prbs_next(st_q.sr);
        miss  = rx_bit ^ pred;
        if (adv) begin
            if (!st_q.locked) begin
                // acquisition: the register reloads from the line
                st_d.sr = {st_q.sr[PRBS_W-2:0], rx_bit};
                if (st_q.fill != FILL_W'(PRBS_W)) begin
                    st_d.fill = st_q.fill + 1'b1;
                end else if (miss || (st_q.sr == '0)) begin
                    st_d.run = '0;
                end else if (st_q.run == RUN_W'(LOCK_RUN - 1)) begin
                    st_d.locked = 1'b1;
                    st_d.run    = '0;
                    st_d.win    = '0;
                    st_d.werr   = '0;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                // locked: the reference runs freely
                st_d.sr = {st_q.sr[PRBS_W-2:0], pred};
                hit_d   = miss;
                if (miss && (st_q.werr == ERR_W'(LOSS_ERRS - 1))) begin
                    st_d.locked = 1'b0;
                    st_d.fill   = '0;
                    st_d.run    = '0;
                    st_d.win    = '0;
                    st_d.werr   = '0;
                end else if (st_q.win == WIN_W'(WIN_LEN - 1)) begin
                    st_d.win  = '0;
                    st_d.werr = '0;
                end else begin
                    st_d.win  = st_q.win + 1'b1;
                    st_d.werr = st_q.werr + ERR_W'(miss);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked  = st_q.locked;
    assign err_hit = hit_d;

endmodule

// File: rtl/e1_sat_counter.sv
module e1_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && (st_q.cnt != '1)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/e1_prbs_engine.sv
module e1_prbs_engine #(
    parameter int TS_W      = 5,
    parameter int CNT_W     = 32,
    parameter int LOCK_RUN  = 64,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [TS_W-1:0]  ts_num,
    input  logic             err_clr,
    input  logic             rx_bit,
    output logic             tx_bit,
    output logic             locked,
    output logic [CNT_W-1:0] err_count
);

    logic payload_ts;
    logic payload_adv;
    logic gen_bit;
    logic err_hit;

    // only the overhead timeslot is skipped
    assign payload_ts  = (ts_num != '0);
    assign payload_adv = bit_en && payload_ts;

    e1_prbs_gen u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (payload_adv),
        .seq_bit (gen_bit)
    );

    assign tx_bit = payload_ts ? gen_bit : 1'b0;

    e1_prbs_chk #(
        .LOCK_RUN  (LOCK_RUN),
        .WIN_LEN   (WIN_LEN),
        .LOSS_ERRS (LOSS_ERRS)
    ) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (payload_adv),
        .rx_bit  (rx_bit),
        .locked  (locked),
        .err_hit (err_hit)
    );

    e1_sat_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (err_clr),
        .inc   (err_hit),
        .count (err_count)
    );

endmodule

// File: rtl/e1_prbs_engine_sva.sv
module e1_prbs_engine_sva #(
    parameter int TS_W  = 5,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic [TS_W-1:0]  ts_num,
    input logic             err_clr,
    input logic             tx_bit,
    input logic             locked,
    input logic [CNT_W-1:0] err_count
);

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (err_count == '0));

    assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_count == $past(err_count)) ||
                      (err_count == $past(err_count) + 1'b1)));

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_count == '1) && !err_clr) |=> (err_count == '1));

    assert_count_when_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !err_clr) |=> $stable(err_count));

    assert_skip_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((!bit_en || (ts_num == '0)) && !err_clr) |=> ($stable(err_count) && $stable(locked)));

    assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && (ts_num != '0)) |=> ($stable(ts_num) -> $stable(tx_bit)));

endmodule

bind e1_prbs_engine e1_prbs_engine_sva #(
    .TS_W  (TS_W),
    .CNT_W (CNT_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .ts_num    (ts_num),
    .err_clr   (err_clr),
    .tx_bit    (tx_bit),
    .locked    (locked),
    .err_count (err_count)
);

// File: tb/sim_e1_prbs_engine.sv
`timescale 1ns/1ps
module sim_e1_prbs_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic [4:0]  ts_num = '0;
    logic        err_clr = 1'b0;
    logic        rx_bit = 1'b0;
    logic        tx0, tx1;
    logic        lk0, lk1;
    logic [31:0] cnt0;
    logic [2:0]  cnt1;

    always #10 clk = ~clk;

    e1_prbs_engine u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ts_num(ts_num),
        .err_clr(err_clr), .rx_bit(rx_bit), .tx_bit(tx0),
        .locked(lk0), .err_count(cnt0)
    );

    // narrow counter instance to reach saturation
    e1_prbs_engine #(.CNT_W(3)) u1 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ts_num(ts_num),
        .err_clr(1'b0), .rx_bit(rx_bit), .tx_bit(tx1),
        .locked(lk1), .err_count(cnt1)
    );

    int tests = 0;
    int fails = 0;
    int tx_bad = 0;
    int ts0_bad = 0;
    bit finished = 0;
    logic [14:0] model = '1;
    int ts_pos = 0;
    int bit_pos = 0;
    logic en_phase = 1'b0;
    logic junk = 1'b0;

    // nbits, nflip, stride, expected lock, expected total errors
    localparam int NVEC = 5;
    localparam int VEC [NVEC][5] = '{
        '{100, 0,  1, 1, 0},   // R4 acquisition
        '{200, 1,  1, 1, 1},   // R5 single flip counts once
        '{64,  7,  8, 1, 8},   // R6 seven spread errors keep lock
        '{64,  16, 1, 0, 14},  // R6 burst drops lock; R7 only locked errors count
        '{120, 0,  1, 1, 14}   // R4 reacquisition
    };

    task automatic check(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one payload bit; bit_en alternates, excluded slots get junk on rx (R3)
    task automatic send_bit(input logic flip, input logic zero);
        bit done = 0;
        logic e;
        while (!done) begin
            @(negedge clk);
            en_phase = ~en_phase;
            bit_en   = en_phase;
            ts_num   = 5'(ts_pos);
            #1;
            if (bit_en && ts_pos != 0) begin
                e = model[14] ^ model[13];
                if (tx0 !== e) tx_bad++;
                rx_bit = zero ? 1'b0 : (tx0 ^ flip);
                model  = {model[13:0], e};
                done   = 1;
            end else begin
                if (ts_pos == 0 && tx0 !== 1'b0) ts0_bad++;
                rx_bit = junk;
                junk   = ~junk;
            end
            if (bit_en) begin
                bit_pos++;
                if (bit_pos == 8) begin
                    bit_pos = 0;
                    ts_pos  = (ts_pos + 1) % 32;
                end
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bit_en  = 1'b0;
        err_clr = 1'b0;
        en_phase = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 locked in reset", lk0, 0);
        check("R10 count in reset", cnt0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 locked after reset", lk0, 0);
        check("R10 count after reset", cnt0, 0);

        for (int v = 0; v < NVEC; v++) begin
            for (int i = 0; i < VEC[v][0]; i++) begin
                send_bit((i % VEC[v][2] == 0) && (i / VEC[v][2] < VEC[v][1]), 1'b0);
            end
            idle();
            check($sformatf("R4/R6 lock after vector %0d", v), lk0, VEC[v][3]);
            check($sformatf("R5/R7 errors after vector %0d", v), cnt0, VEC[v][4]);
        end
        check("R7 narrow counter saturates", cnt1, 7);
        check("R1 tx sequence mismatches", tx_bad, 0);
        check("R2 tx zero in timeslot 0", ts0_bad, 0);

        // R8 clear, lock unaffected
        @(negedge clk);
        err_clr = 1'b1;
        idle();
        check("R8 count cleared", cnt0, 0);
        check("R8 lock kept over clear", lk0, 1);

        // R8 clear wins over a simultaneous error
        err_clr = 1'b1;
        send_bit(1'b1, 1'b0);
        idle();
        check("R8 clear beats increment", cnt0, 0);

        send_bit(1'b1, 1'b0);
        idle();
        check("R5 one flip one error", cnt0, 1);

        // R9 stuck-at-zero never locks
        for (int i = 0; i < 300; i++) send_bit(1'b0, 1'b1);
        idle();
        check("R9 no lock on all zeros", lk0, 0);

        for (int i = 0; i < 100; i++) send_bit(1'b0, 1'b0);
        idle();
        check("R4 relock after zeros", lk0, 1);
        check("R1 tx sequence after all tests", tx_bad, 0);
        check("R3 excluded slots: narrow instance lock agrees", lk1, lk0);

        finish_run();
    end

endmodule